// File: doc/BRIEF.md
# Serial EEPROM Device Command Engine

This block is the device side of a word-organised serial EEPROM, with a register array standing in for the memory cells. A host drives a serial clock, an active-low select, a data input and a write-control input. The block drives a serial data output with a separate enable, so the output can float, and a ready/busy flag. All four host pins are brought into the system clock domain through synchronisers. Each edge of the serial clock is then found by comparing the synchronised level with its value one system clock earlier.

A transaction is framed by the select line. The first eight bits are a fixed start pattern followed by an opcode. They are followed by an eight-bit address field and, for a write, a sixteen-bit data word; address and data travel least significant bit first. Reads stream words from ascending addresses for as long as the host keeps clocking. Writes start a self-timed programming cycle, whose length is a parameter counted in system clocks. The host can watch the cycle on the busy flag, or poll it on the data output.

The pins form a plain serial protocol, not a stream interface. There is no back-pressure: the host owns the serial clock, and the block must keep pace with every edge. The serial clock must stay well below the system clock; each serial half-period needs at least four system clocks.

Top module: `sser_eeprom`

## Requirements
- R1: After reset, `rdy_o` is 1, `do_oe_o` is 0, the write-enable latch is clear and every word of the array reads 16'hFFFF.
- R2: Bits 1–4 of a frame must be 1,0,1,0 (first bit sent first). With any other pattern, the frame has no effect, and `do_oe_o` stays 0 until select goes high.
- R3: Read opcode 4'b1000 (bits 5–8, first bit sent first). After the 8 address bits, the addressed word's bit 0 appears on DO after the falling serial edge of clock 16. One more bit follows on each falling edge. After bit 15, the next address (modulo the word count) follows with no gap.
- R4: While the synchronised select is high, `do_oe_o` is 0, and any read or partial frame is discarded.
- R5: Write enable is opcode 4'b0011 and write disable is opcode 4'b0000. A write (opcode 4'b0100) issued while the latch is clear has no effect: `rdy_o` stays 1 and the word keeps its value.
- R6: An enabled write starts programming on the rising serial edge of clock 32. `rdy_o` then stays 0 for PROG_CYCLES system clocks, and the new word is stored when `rdy_o` returns to 1.
- R7: If write-control is high at any time during a write frame, up to and including clock 32, no programming starts and the stored word is unchanged.
- R8: If write-control goes high during programming, the cycle ends within a few system clocks and the target word becomes 16'hFFFF (erased, not programmed).
- R9: After a programming cycle has started, a falling select while the serial clock is low drives the inverted busy state onto DO with `do_oe_o` = 1 until select rises.
- R10: While programming runs, no frame bits are accepted. After it ends, a select that never went high keeps all further input ignored until select goes high once.
- R11: Enable and disable act on clock 8 regardless of write-control; the address clocks that follow are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| sk_i | input | 1 | Serial clock from host |
| sel_n_i | input | 1 | Active-low select |
| di_i | input | 1 | Serial data in |
| wc_i | input | 1 | Write-control (high blocks or aborts writes) |
| do_o | output | 1 | Serial data / status out |
| do_oe_o | output | 1 | Output enable for DO (0 = high impedance) |
| rdy_o | output | 1 | Ready (1) / busy (0) |

## Verification
The bench crosses word boundaries during sequential reads, including the wrap from the top address to zero. A design that forgot the increment, or reloaded one clock late, would repeat a word or drop its first bit. It sends a write with the latch clear, a write with a one-bit write-control pulse, and a write aborted mid-cycle. A design that ignored any of these guards would alter memory or hold busy for the full time. It also polls status on DO and keeps select low across the end of programming. A design that accepted a command there, or never drove status, would show the output enable set, or clear, at the wrong time.

// File: rtl/sser_pkg.sv
package sser_pkg;
  localparam int WORD_W    = 16;
  localparam int CMD_LEN   = 8;
  localparam int ADR_LEN   = 8;
  localparam int FRAME_LEN = CMD_LEN + ADR_LEN + WORD_W;
  localparam logic [3:0] START_PAT = 4'b1010;

  typedef enum logic [3:0] {
    OP_READ  = 4'b1000,
    OP_WRITE = 4'b0100,
    OP_WEN   = 4'b0011,
    OP_WDS   = 4'b0000
  } sser_op_e;
endpackage

// File: rtl/sser_pin_sync.sv
module sser_pin_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sser_word_array.sv
module sser_word_array #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/sser_prog_timer.sv
module sser_prog_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o,
  output logic abort_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o  <= 1'b0;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_o  <= 1'b0;
      abort_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_o) begin
        if (abort_i) begin
          busy_o  <= 1'b0;
          abort_o <= 1'b1;
        end else if (cnt_q == LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_q <= LAST));
  assert_start_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/sser_eeprom.sv
module sser_eeprom
  import sser_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sk_i,
  input  logic sel_n_i,
  input  logic di_i,
  input  logic wc_i,
  output logic do_o,
  output logic do_oe_o,
  output logic rdy_o
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] N_CMD = CNT_W'(CMD_LEN);
  localparam logic [CNT_W-1:0] N_ADR = CNT_W'(CMD_LEN + ADR_LEN);
  localparam logic [CNT_W-1:0] N_END = CNT_W'(FRAME_LEN);

  // synchronised pins: {wc, di, sel_n, sk}
  logic [3:0] pins_s;
  logic sk_s, sel_s, di_s, wc_s, sk_p, sel_p;

  sser_pin_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({wc_i, di_i, sel_n_i, sk_i}),
    .q_o(pins_s)
  );
  assign sk_s  = pins_s[0];
  assign sel_s = pins_s[1];
  assign di_s  = pins_s[2];
  assign wc_s  = pins_s[3];

  logic sk_rise, sk_fall, sel_fall;
  assign sk_rise  = sk_s & ~sk_p;
  assign sk_fall  = ~sk_s & sk_p;
  assign sel_fall = ~sel_s & sel_p;

  // frame state
  logic [CNT_W-1:0]  bitcnt_q;
  logic [7:0]        cmd_q, adr_q;
  logic [3:0]        op_q;
  logic [WORD_W-1:0] wsh_q;
  logic armed_q, frm_done_q, wen_q, wc_hit_q, poll_pend_q, stat_on_q;
  // read path
  logic              rd_on_q;
  logic [ADDR_W-1:0] rd_adr_q;
  logic [3:0]        rpos_q;
  logic              do_q, do_oe_q;
  // programming target
  logic [ADDR_W-1:0] prog_adr_q;
  logic [WORD_W-1:0] prog_dat_q;

  logic tmr_busy, tmr_done, tmr_abort;
  logic [WORD_W-1:0] rdata;
  logic arr_we;
  logic [WORD_W-1:0] arr_wdata;

  logic [CNT_W-1:0]  nxt_cnt;
  logic [7:0]        cmd_nxt, adr_nxt;
  logic [WORD_W-1:0] wsh_nxt;
  logic accept, shift_en, prog_go;

  always_comb begin
    nxt_cnt  = bitcnt_q + 1'b1;
    cmd_nxt  = {cmd_q[6:0], di_s};
    adr_nxt  = {di_s, adr_q[7:1]};
    wsh_nxt  = {di_s, wsh_q[WORD_W-1:1]};
    accept   = armed_q & ~tmr_busy & ~frm_done_q & ~sel_s;
    shift_en = accept & sk_rise;
    prog_go  = shift_en && (nxt_cnt == N_END) && (op_q == OP_WRITE)
               && wen_q && !wc_hit_q && !wc_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sk_p <= 1'b0;
      sel_p <= 1'b1;
    end else begin
      sk_p <= sk_s;
      sel_p <= sel_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt_q    <= '0;
      cmd_q       <= '0;
      adr_q       <= '0;
      op_q        <= '0;
      wsh_q       <= '0;
      armed_q     <= 1'b0;
      frm_done_q  <= 1'b0;
      wen_q       <= 1'b0;
      wc_hit_q    <= 1'b0;
      poll_pend_q <= 1'b0;
      stat_on_q   <= 1'b0;
      rd_on_q     <= 1'b0;
      rd_adr_q    <= '0;
      rpos_q      <= '0;
      do_q        <= 1'b0;
      do_oe_q     <= 1'b0;
      prog_adr_q  <= '0;
      prog_dat_q  <= '0;
    end else if (sel_s) begin
      bitcnt_q   <= '0;
      frm_done_q <= 1'b0;
      rd_on_q    <= 1'b0;
      do_oe_q    <= 1'b0;
      stat_on_q  <= 1'b0;
      wc_hit_q   <= 1'b0;
      if (!tmr_busy) begin
        armed_q     <= 1'b1;
        poll_pend_q <= 1'b0;
      end
    end else begin
      if (wc_s) wc_hit_q <= 1'b1;
      if (sel_fall && poll_pend_q && !sk_s) begin
        stat_on_q <= 1'b1;
        do_oe_q   <= 1'b1;
      end
      if (stat_on_q) do_q <= ~tmr_busy;

      if (shift_en) begin
        bitcnt_q <= nxt_cnt;
        if (nxt_cnt <= N_CMD) begin
          cmd_q <= cmd_nxt;
          if (nxt_cnt == N_CMD) begin
            op_q <= cmd_nxt[3:0];
            if (cmd_nxt[7:4] != START_PAT) begin
              frm_done_q <= 1'b1;
            end else if (cmd_nxt[3:0] == OP_WEN) begin
              wen_q <= 1'b1;
              frm_done_q <= 1'b1;
            end else if (cmd_nxt[3:0] == OP_WDS) begin
              wen_q <= 1'b0;
              frm_done_q <= 1'b1;
            end else if (cmd_nxt[3:0] != OP_READ && cmd_nxt[3:0] != OP_WRITE) begin
              frm_done_q <= 1'b1;
            end
          end
        end else if (nxt_cnt <= N_ADR) begin
          adr_q <= adr_nxt;
          if (nxt_cnt == N_ADR && op_q == OP_READ) begin
            rd_on_q    <= 1'b1;
            rd_adr_q   <= adr_nxt[ADDR_W-1:0];
            rpos_q     <= '0;
            frm_done_q <= 1'b1;
          end
        end else begin
          wsh_q <= wsh_nxt;
          if (nxt_cnt == N_END) frm_done_q <= 1'b1;
        end
      end

      if (prog_go) begin
        armed_q     <= 1'b0;
        poll_pend_q <= 1'b1;
        prog_adr_q  <= adr_q[ADDR_W-1:0];
        prog_dat_q  <= wsh_nxt;
      end

      if (sk_fall && rd_on_q) begin
        do_oe_q <= 1'b1;
        do_q    <= rdata[rpos_q];
        rpos_q  <= rpos_q + 1'b1;
        if (rpos_q == 4'hF) rd_adr_q <= rd_adr_q + 1'b1;
      end
    end
  end

  sser_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start_i(prog_go), .abort_i(wc_s),
    .busy_o(tmr_busy), .done_o(tmr_done), .abort_o(tmr_abort)
  );

  assign arr_we    = tmr_done | tmr_abort;
  assign arr_wdata = tmr_done ? prog_dat_q : '1;

  sser_word_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .we_i(arr_we), .waddr_i(prog_adr_q), .wdata_i(arr_wdata),
    .raddr_i(rd_adr_q), .rdata_o(rdata)
  );

  assign do_o    = do_q;
  assign do_oe_o = do_oe_q;
  assign rdy_o   = ~tmr_busy;

  assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sel_s |=> !do_oe_q);
  assert_start_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_busy) |-> $past(wen_q));
  assert_store_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tmr_busy) |-> arr_we);
  assert_wc_aborts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_busy && wc_s) |=> !tmr_busy);
  assert_busy_freezes_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_busy && !sel_s) |=> $stable(bitcnt_q));
endmodule

// File: tb/sser_eeprom_tb_top.sv
`timescale 1ns/1ps
module sser_eeprom_tb_top;
  localparam int H = 6;
  localparam int PROG = 200;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, sk = 1'b0, sel_n = 1'b1, di = 1'b0, wc = 1'b0;
  logic do_o, do_oe, rdy;

  sser_eeprom #(.ADDR_W(8), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .sk_i(sk), .sel_n_i(sel_n), .di_i(di), .wc_i(wc),
    .do_o(do_o), .do_oe_o(do_oe), .rdy_o(rdy)
  );

  int n_cmp = 0, n_bad = 0;
  int mem_m [256];
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input bit b, output bit o, output bit oe);
    di = b;
    wait_clk(H);
    o = do_o; oe = do_oe;
    sk = 1'b1;
    wait_clk(H);
    sk = 1'b0;
  endtask

  task automatic shift(input bit b);
    bit o, oe;
    bitx(b, o, oe);
  endtask

  task automatic sel_lo(); sel_n = 1'b0; wait_clk(4); endtask
  task automatic sel_hi(); sel_n = 1'b1; wait_clk(8); endtask

  task automatic head(input bit [7:0] c, input bit [7:0] a);
    for (int i = 7; i >= 0; i--) shift(c[i]);
    for (int i = 0; i < 8; i++) shift(a[i]);
  endtask

  task automatic read_words(input int a, input int nw, input string req);
    bit o, oe;
    sel_lo();
    head(8'b1010_1000, a[7:0]);
    for (int w = 0; w < nw; w++) begin
      bit [15:0] got = '0;
      bit all_oe = 1'b1;
      int ex = mem_m[(a + w) % 256];
      for (int k = 0; k < 16; k++) begin
        bitx(1'b0, o, oe);
        got[k] = o;
        all_oe &= oe;
      end
      chk(all_oe && (int'(got) == ex), req, int'(got), ex);
    end
    sel_hi();
    chk(do_oe == 1'b0, "R4", int'(do_oe), 0);
  endtask

  task automatic write_word(input int a, input bit [15:0] d, input int wc_bit);
    sel_lo();
    head(8'b1010_0100, a[7:0]);
    for (int i = 0; i < 16; i++) begin
      wc = (i == wc_bit);
      shift(d[i]);
    end
    wc = 1'b0;
  endtask

  task automatic cmd_only(input bit [3:0] op);
    sel_lo();
    head({4'b1010, op}, 8'hA5);
    sel_hi();
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!rdy && n < PROG * 4) begin
      wait_clk(1);
      n++;
    end
  endtask

  // every clock: a deselected device never drives DO (R4)
  int sel_hold = 0;
  always @(negedge clk) begin
    if (rst_n && sel_n) sel_hold++; else sel_hold = 0;
    if (sel_hold > 4 && !done_flag) chk(do_oe == 1'b0, "R4", int'(do_oe), 0);
  end

  initial begin
    wait_clk(150000);
    if (!done_flag) begin
      chk(1'b0, "WATCHDOG", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    bit o, oe, any_oe;
    for (int i = 0; i < 256; i++) mem_m[i] = 16'hFFFF;
    wait_clk(10);
    rst_n = 1'b1;
    wait_clk(10);

    chk(rdy == 1'b1, "R1", int'(rdy), 1);
    chk(do_oe == 1'b0, "R1", int'(do_oe), 0);
    read_words(5, 1, "R1");

    // R5: write with latch clear
    write_word(5, 16'h1234, -1);
    sel_hi(); wait_clk(5);
    chk(rdy == 1'b1, "R5", int'(rdy), 1);
    read_words(5, 1, "R5");

    // R11: enable with write-control high and garbage address
    wc = 1'b1; cmd_only(4'b0011); wc = 1'b0;

    // R6: enabled write
    write_word(5, 16'h1234, -1);
    chk(rdy == 1'b0, "R6", int'(rdy), 0);
    sel_hi();
    wait_ready(n);
    chk(n > PROG - 40 && n <= PROG, "R6", n, PROG - 11);
    mem_m[5] = 16'h1234;
    read_words(5, 1, "R6");

    // R3: sequential reads and wrap
    write_word(6, 16'hA5C3, -1); sel_hi(); wait_ready(n); mem_m[6] = 16'hA5C3;
    write_word(255, 16'hBEEF, -1); sel_hi(); wait_ready(n); mem_m[255] = 16'hBEEF;
    wait_clk(10);
    read_words(5, 2, "R3");
    read_words(255, 2, "R3");

    // R4: cancel mid-read
    sel_lo();
    head(8'b1010_1000, 8'd5);
    for (int i = 0; i < 20; i++) shift(1'b0);
    sel_n = 1'b1; wait_clk(5);
    chk(do_oe == 1'b0, "R4", int'(do_oe), 0);
    wait_clk(5);

    // R2: bad start pattern
    sel_lo();
    head(8'b1110_1000, 8'd5);
    any_oe = 1'b0;
    for (int i = 0; i < 32; i++) begin bitx(1'b0, o, oe); any_oe |= oe; end
    chk(any_oe == 1'b0, "R2", int'(any_oe), 0);
    sel_hi();

    // R7: momentary write-control in the frame
    write_word(6, 16'h0000, 4);
    sel_hi(); wait_clk(5);
    chk(rdy == 1'b1, "R7", int'(rdy), 1);
    read_words(6, 1, "R7");

    // R9: status poll on DO
    write_word(7, 16'h3C3C, -1);
    sel_hi();
    sel_n = 1'b0; wait_clk(6);
    chk(do_oe == 1'b1 && do_o == 1'b0, "R9", {do_oe, do_o}, 2);
    wait_ready(n); wait_clk(6);
    chk(do_oe == 1'b1 && do_o == 1'b1, "R9", {do_oe, do_o}, 3);
    sel_hi();
    mem_m[7] = 16'h3C3C;

    // R10: select held low across end of programming
    write_word(8, 16'h5555, -1);
    wait_ready(n);
    head(8'b1010_1000, 8'd8);
    any_oe = 1'b0;
    for (int i = 0; i < 32; i++) begin bitx(1'b0, o, oe); any_oe |= oe; end
    chk(any_oe == 1'b0, "R10", int'(any_oe), 0);
    sel_hi();
    mem_m[8] = 16'h5555;
    read_words(8, 1, "R10");

    // R8: abort during programming
    write_word(9, 16'h1111, -1); sel_hi(); wait_ready(n); mem_m[9] = 16'h1111;
    write_word(9, 16'h0F0F, -1);
    sel_hi(); wait_clk(20);
    wc = 1'b1; wait_clk(6);
    chk(rdy == 1'b1, "R8", int'(rdy), 1);
    wc = 1'b0;
    mem_m[9] = 16'hFFFF;
    read_words(9, 1, "R8");

    // R5: disable blocks writes again
    cmd_only(4'b0000);
    write_word(5, 16'hDEAD, -1);
    sel_hi(); wait_clk(5);
    chk(rdy == 1'b1, "R5", int'(rdy), 1);
    read_words(5, 1, "R5");

    done_flag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule